// File: doc/BRIEF.md
# Peak Hold and Reset Sequencer

This block is the digital control of a five-channel pulse-height front end. Each channel contributes two flags: one saying that its input is above the discriminator threshold, and one saying that a negative-going zero crossing occurred. A channel becomes armed once its input has been over threshold. The first zero crossing seen on any armed channel opens a short request window. If no conversion request arrives before the window ends, a one-cycle clear pulse resets every peak detector and disarms every channel.

A conversion request that lands inside the window sets the hold output instead. Hold freezes all peaks for a fixed conversion interval. When that interval ends, hold drops and the clear pulse is issued. The request input is asynchronous. It passes through a synchronizer and an edge detector, so each rising edge counts once. Requests that arrive outside the window, or while hold is already set, are dropped and flagged on a one-cycle reject strobe.

The block also drives two power enables. Converter cycle power is on for the conversion cycle only. Peak-detector power is on only while the converter is powered and the telescope mode is selected. The block carries no data stream, so every pin is a plain level or strobe and there is no valid/ready handshake. Window and conversion lengths are parameters counted in clock cycles. The defaults (2 and 910) assume a 1 MHz clock.

Top module: `peak_hold_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the block enters idle after that edge. `hold`, `pd_reset`, `req_reject`, `conv_pwr_en`, `pd_pwr_en` and every bit of `armed` are then 0.
- R2: `armed[i]` rises at the edge after `over_thr[i]` is sampled high. A zero crossing on a channel whose `armed` bit is 0 never opens a window.
- R3: Let edge E0 be the idle-state edge at which `zero_x[i] & armed[i]` is high for some channel. If no request is accepted, `pd_reset` is high for the one cycle after edge E0+WIN_CYC, and `armed` is all 0 in that same cycle.
- R4: The window accepts a request at edges E0+1 through E0+WIN_CYC; a request wins over the window end at the last edge. An accepted request raises `hold` after edge A, for CONV_CYC cycles, with `pd_reset` kept low. `pd_reset` pulses in the cycle in which `hold` returns to 0.
- R5: A request pulse sampled while the block is idle or holding leaves the state unchanged. It raises `req_reject` for the one cycle after that edge.
- R6: A rising `conv_req` first sampled at edge k acts as a request at edge k+2. A level held high over many cycles counts as one request.
- R7: `conv_pwr_en` is 0 in idle and during the window. It is 1 for exactly the cycles in which `hold` is 1.
- R8: `pd_pwr_en` equals `conv_pwr_en` ANDed with `tel_mode` as sampled at the same edge.
- R9: Zero crossings during the window or the hold neither restart nor extend them. Channels can still become armed then, and they are disarmed by the next clear pulse.
- R10: `pd_reset` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tel_mode | input | 1 | Telescope mode select; gates peak-detector power |
| over_thr | input | NUM_CH | Per-channel discriminator over-threshold flag |
| zero_x | input | NUM_CH | Per-channel negative-going zero-crossing flag |
| conv_req | input | 1 | Asynchronous conversion request |
| pd_reset | output | 1 | One-cycle clear pulse for all peak detectors |
| hold | output | 1 | Peak freeze, high for the conversion interval |
| req_reject | output | 1 | One-cycle strobe for a dropped request |
| conv_pwr_en | output | 1 | Converter cycle power enable |
| pd_pwr_en | output | 1 | Peak-detector power enable |
| armed | output | NUM_CH | Per-channel armed state |

## Verification
The hardest case to reach from the ports is a request that reaches the sequencer on the exact edge where the window would expire. The same applies one edge earlier and one edge later. Because of the synchronizer latency, the raw request must be raised two edges ahead, and sometimes before the zero crossing itself. The bench therefore sweeps the raw request edge over a range that starts before the crossing and ends past the window. It repeats this for every channel and both mode settings. Each pass also injects a second request during the hold, a stray crossing on an unarmed channel, a repeat crossing inside the window, and a late arming of a third channel. For every cycle, the bench computes the expected hold, clear, reject, power and armed values from the request edge arithmetic.

// File: rtl/psq_pkg.sv
package psq_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_WINDOW = 2'd1,
    SQ_HOLD   = 2'd2
  } sq_state_e;

  // Bits needed to count up to the larger of two cycle limits
  function automatic int cnt_bits(input int a, input int b);
    int m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m + 1);
  endfunction

endpackage

// File: rtl/psq_req_sync.sv
module psq_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_async,
  output logic req_pulse
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= req_async;
  end

  for (genvar g = 1; g <= STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[g] <= 1'b0;
      else     chain[g] <= chain[g-1];
    end
  end

  assign req_pulse = chain[STAGES-1] & ~chain[STAGES];

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    req_pulse |=> !req_pulse); // R6

endmodule

// File: rtl/psq_arm_bank.sv
module psq_arm_bank #(
  parameter int NUM_CH = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [NUM_CH-1:0] over_thr,
  input  logic [NUM_CH-1:0] zero_x,
  output logic [NUM_CH-1:0] armed,
  output logic              trig
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst || clr)       armed[c] <= 1'b0;
      else if (over_thr[c]) armed[c] <= 1'b1;
    end
  end

  assign trig = |(armed & zero_x);

endmodule

// File: rtl/psq_seq_fsm.sv
module psq_seq_fsm
  import psq_pkg::*;
#(
  parameter int WIN_CYC  = 2,
  parameter int CONV_CYC = 910
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  input  logic req_pulse,
  output logic accept,
  output logic conv_end,
  output logic fire,
  output logic pd_reset,
  output logic hold,
  output logic req_reject
);
  localparam int CW = cnt_bits(WIN_CYC, CONV_CYC);
  localparam logic [CW-1:0] WIN_LAST  = CW'(WIN_CYC - 1);
  localparam logic [CW-1:0] CONV_LAST = CW'(CONV_CYC - 1);

  sq_state_e     state;
  logic [CW-1:0] cnt;
  logic          win_end;

  // A request on the last window edge wins over the window expiring
  assign accept   = (state == SQ_WINDOW) && req_pulse;
  assign win_end  = (state == SQ_WINDOW) && !req_pulse && (cnt == WIN_LAST);
  assign conv_end = (state == SQ_HOLD) && (cnt == CONV_LAST);
  assign fire     = win_end || conv_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SQ_IDLE;
      cnt        <= '0;
      pd_reset   <= 1'b0;
      hold       <= 1'b0;
      req_reject <= 1'b0;
    end else begin
      pd_reset   <= fire;
      req_reject <= req_pulse && (state != SQ_WINDOW);
      unique case (state)
        SQ_IDLE: begin
          cnt <= '0;
          if (trig) state <= SQ_WINDOW;
        end
        SQ_WINDOW: begin
          if (accept) begin
            state <= SQ_HOLD;
            hold  <= 1'b1;
            cnt   <= '0;
          end else if (win_end) begin
            state <= SQ_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SQ_HOLD: begin
          if (conv_end) begin
            state <= SQ_IDLE;
            hold  <= 1'b0;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state <= SQ_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  AST_RESET_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pd_reset |=> !pd_reset); // R10
  AST_NO_CLEAR_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
    hold |-> !pd_reset); // R4
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_HOLD) |-> (cnt <= CONV_LAST)); // R4

endmodule

// File: rtl/psq_pwr_gate.sv
module psq_pwr_gate (
  input  logic clk,
  input  logic rst,
  input  logic conv_start,
  input  logic conv_end,
  input  logic tel_mode,
  output logic conv_pwr_en,
  output logic pd_pwr_en
);
  logic conv_nxt;

  always_comb begin
    if (conv_start)    conv_nxt = 1'b1;
    else if (conv_end) conv_nxt = 1'b0;
    else               conv_nxt = conv_pwr_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      conv_pwr_en <= 1'b0;
      pd_pwr_en   <= 1'b0;
    end else begin
      conv_pwr_en <= conv_nxt;
      pd_pwr_en   <= tel_mode & conv_nxt;
    end
  end

  AST_PD_NEEDS_CONV: assert property (@(posedge clk) disable iff (rst)
    pd_pwr_en |-> conv_pwr_en); // R8

endmodule

// File: rtl/peak_hold_seq.sv
module peak_hold_seq #(
  parameter int NUM_CH      = 5,
  parameter int WIN_CYC     = 2,
  parameter int CONV_CYC    = 910,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tel_mode,
  input  logic [NUM_CH-1:0] over_thr,
  input  logic [NUM_CH-1:0] zero_x,
  input  logic              conv_req,
  output logic              pd_reset,
  output logic              hold,
  output logic              req_reject,
  output logic              conv_pwr_en,
  output logic              pd_pwr_en,
  output logic [NUM_CH-1:0] armed
);
  logic req_pulse, trig, accept, conv_end, fire;

  psq_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .req_async(conv_req), .req_pulse(req_pulse)
  );

  psq_arm_bank #(.NUM_CH(NUM_CH)) u_arm (
    .clk(clk), .rst(rst), .clr(fire), .over_thr(over_thr),
    .zero_x(zero_x), .armed(armed), .trig(trig)
  );

  psq_seq_fsm #(.WIN_CYC(WIN_CYC), .CONV_CYC(CONV_CYC)) u_fsm (
    .clk(clk), .rst(rst), .trig(trig), .req_pulse(req_pulse),
    .accept(accept), .conv_end(conv_end), .fire(fire),
    .pd_reset(pd_reset), .hold(hold), .req_reject(req_reject)
  );

  psq_pwr_gate u_pwr (
    .clk(clk), .rst(rst), .conv_start(accept), .conv_end(conv_end),
    .tel_mode(tel_mode), .conv_pwr_en(conv_pwr_en), .pd_pwr_en(pd_pwr_en)
  );

  AST_CLEAR_DISARMS: assert property (@(posedge clk) disable iff (rst)
    pd_reset |-> (armed == '0)); // R3
  AST_HOLD_POWERED: assert property (@(posedge clk) disable iff (rst)
    hold |-> conv_pwr_en); // R7
  AST_HOLD_ENDS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ($fell(hold) && !$past(rst)) |-> pd_reset); // R4
  AST_REJECT_NO_START: assert property (@(posedge clk) disable iff (rst)
    req_reject |-> !$rose(hold)); // R5

endmodule

// File: tb/sim_peak_hold_seq.sv
`timescale 1ns/1ps
module sim_peak_hold_seq;
  localparam int NCH  = 5;
  localparam int WIN  = 3;
  localparam int CONV = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tel_mode = 1'b0;
  logic [NCH-1:0] over_thr = '0;
  logic [NCH-1:0] zero_x = '0;
  logic conv_req = 1'b0;
  logic pd_reset, hold, req_reject, conv_pwr_en, pd_pwr_en;
  logic [NCH-1:0] armed;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  peak_hold_seq #(.NUM_CH(NCH), .WIN_CYC(WIN), .CONV_CYC(CONV)) u0 (
    .clk(clk), .rst(rst), .tel_mode(tel_mode), .over_thr(over_thr),
    .zero_x(zero_x), .conv_req(conv_req), .pd_reset(pd_reset), .hold(hold),
    .req_reject(req_reject), .conv_pwr_en(conv_pwr_en), .pd_pwr_en(pd_pwr_en),
    .armed(armed)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected outputs after edge e of one sweep case
  task automatic check_edge(input int e, input int ch, input int q, input bit mode);
    int a, rr, o2, exp_arm;
    bit acc, exp_hold, exp_rst, exp_rej;
    a   = q + 2;                           // R6: two-edge latency
    acc = (a >= 1) && (a <= WIN);          // R4: window edges E0+1..E0+WIN
    rr  = acc ? a + CONV : WIN;            // R3 / R4 clear edge
    o2  = (ch + 2) % NCH;
    exp_hold = acc && (e >= a) && (e < a + CONV);
    exp_rst  = (e == rr);
    exp_rej  = (!acc && e == a) || (e == a + 6);
    if (e < -6 || e >= rr) exp_arm = 0;
    else exp_arm = (1 << ch) | ((e >= 1) ? (1 << o2) : 0);   // R2, R9
    chk("R4 hold", int'(hold), int'(exp_hold));
    chk("R3 pd_reset", int'(pd_reset), int'(exp_rst));
    chk("R5 req_reject", int'(req_reject), int'(exp_rej));
    chk("R9 armed", int'(armed), exp_arm);
    chk("R7 conv_pwr_en", int'(conv_pwr_en), int'(exp_hold));
    chk("R8 pd_pwr_en", int'(pd_pwr_en), int'(exp_hold && mode));
  endtask

  task automatic run_case(input int ch, input int q, input bit mode);
    int a, rr, last, o1;
    a    = q + 2;
    rr   = ((a >= 1) && (a <= WIN)) ? a + CONV : WIN;
    last = ((rr > a + 6) ? rr : a + 6) + 2;
    o1   = (ch + 1) % NCH;
    tel_mode = mode;
    for (int t = -6; t <= last; t++) begin
      @(negedge clk);
      if (t > -6) check_edge(t - 1, ch, q, mode);
      over_thr = (t == -6) ? NCH'(1 << ch) : (t == 1) ? NCH'(1 << ((ch + 2) % NCH)) : '0;
      zero_x   = (t == -3) ? NCH'(1 << o1)                 // R2: unarmed crossing
               : (t == 0 || t == 2) ? NCH'(1 << ch) : '0;  // R9: repeat crossing
      conv_req = ((t >= q) && (t < q + 4)) || ((t >= q + 6) && (t < q + 8));
    end
    over_thr = '0; zero_x = '0; conv_req = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 hold", int'(hold), 0);
    chk("R1 pd_reset", int'(pd_reset), 0);
    chk("R1 req_reject", int'(req_reject), 0);
    chk("R1 conv_pwr_en", int'(conv_pwr_en), 0);
    chk("R1 pd_pwr_en", int'(pd_pwr_en), 0);
    chk("R1 armed", int'(armed), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // Sweep: every channel, both modes, request edge across the window
    for (int ch = 0; ch < NCH; ch++)
      for (int m = 0; m < 2; m++)
        for (int q = -3; q <= WIN + 1; q++)
          run_case(ch, q, m[0]);

    // R1: reset in the middle of a hold
    tel_mode = 1'b1;
    for (int t = -6; t <= 5; t++) begin
      @(negedge clk);
      over_thr = (t == -6) ? NCH'(1) : '0;
      zero_x   = (t == 0) ? NCH'(1) : '0;
      conv_req = (t >= -1) && (t <= 2);
      rst      = (t == 4);
      if (t == 4) chk("R4 hold before reset", int'(hold), 1);
    end
    chk("R1 hold after reset", int'(hold), 0);
    chk("R1 conv_pwr_en after reset", int'(conv_pwr_en), 0);
    chk("R1 pd_pwr_en after reset", int'(pd_pwr_en), 0);
    chk("R1 armed after reset", int'(armed), 0);
    chk("R1 pd_reset after reset", int'(pd_reset), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 no clear after reset", int'(pd_reset), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule